// File: doc/BRIEF.md
# Block-Transfer Address Sequencer

This unit produces the memory side of a multi-register load or store. It receives one request made of a base address, a 16-bit mask of selected registers, a two-bit addressing mode, a load/store flag and a writeback flag. From that request it issues one word-sized memory beat per selected register. Each beat carries an address, a register index, a direction flag and a marker on the final beat. A beat is consumed only when the memory side returns ready, so the sequencer can be stalled for any number of cycles on any beat.

Registers always go out in ascending index order at ascending addresses, so the lowest-numbered register sits at the lowest address in every mode. The mode sets only where that run of addresses starts. When the last beat has been accepted, the unit raises a one-cycle completion strobe and presents the updated base. That value is marked valid only if the request asked for writeback. A request can start only while the busy output is low.

Top module: `blk_xfer_seq`

## Requirements
- R1: After synchronous reset, and whenever reset is applied in the middle of an operation, busy, beat_valid, done and wb_valid are all low on the next cycle.
- R2: Mode 2'b00 (increment, address taken after use): the first beat uses the base, and each later beat adds 4.
- R3: Mode 2'b01 (increment, address advanced before use): the beats use base+4, base+8, and so on.
- R4: Mode 2'b10 (decrement, after): the first beat uses base - 4*n + 4, and later beats step up by 4, where n is the number of set bits in the mask.
- R5: Mode 2'b11 (decrement, before): the first beat uses base - 4*n, and later beats step up by 4.
- R6: Beats name the selected registers in ascending index order, one beat for each set mask bit. Each beat's address is the previous beat's address plus 4, with address arithmetic modulo 2^32.
- R7: A beat completes only on a cycle where beat_valid and beat_ready are both high. While beat_ready is low, the address and register index hold steady.
- R8: beat_last is high only on the beat for the highest selected register.
- R9: On the cycle after the last beat completes, done is high for exactly one cycle and wb_value is presented. wb_value is base + 4*n for modes 00 and 01, and base - 4*n for modes 10 and 11. wb_valid equals the request's writeback flag while done is high.
- R10: An all-zero mask issues no beats. done rises on the cycle after the request, with wb_value equal to the base.
- R11: A start pulse while busy is high is ignored, and the running sequence of addresses and indices is unaffected.
- R12: beat_load repeats the request's load/store flag (1 = load) on every beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken when busy is low |
| base_in | input | 32 | Base address |
| reg_mask | input | 16 | Selected registers, bit i = register i |
| mode | input | 2 | Bit 1: decrement; bit 0: advance before use |
| is_load | input | 1 | 1 = load, 0 = store |
| wb_en | input | 1 | Request writeback of the updated base |
| busy | output | 1 | Operation in progress |
| beat_valid | output | 1 | Memory beat offered |
| beat_ready | input | 1 | Memory accepts the beat |
| beat_addr | output | 32 | Word address of the beat |
| beat_reg | output | 4 | Register index of the beat |
| beat_load | output | 1 | Direction of the beat |
| beat_last | output | 1 | Final beat of the operation |
| done | output | 1 | One-cycle completion strobe |
| wb_valid | output | 1 | Updated base should be written back |
| wb_value | output | 32 | Updated base value |

## Verification
The properties assume that beat_ready is a plain level and that the memory side never withdraws a beat. They also assume that reset may cut a sequence at any point, so every property is disabled during reset. The stimulus drives ready and start one time unit after the rising edge, with stall patterns and start pulses injected while busy. Every request keeps to the 16-bit mask and the four mode codes. Base values near zero and near the top of the address space are included, so the modular wrap stays within what the address properties state.

// File: rtl/blkx_pkg.sv
package blkx_pkg;
  typedef enum logic [1:0] {
    XM_INC_AFTER  = 2'b00,
    XM_INC_BEFORE = 2'b01,
    XM_DEC_AFTER  = 2'b10,
    XM_DEC_BEFORE = 2'b11
  } xfer_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'b00,
    SQ_RUN  = 2'b01,
    SQ_FIN  = 2'b10
  } sq_state_e;
endpackage

// File: rtl/blkx_popcnt.sv
module blkx_popcnt #(
  parameter int W  = 16,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) cnt = cnt + CW'(vec[i]);
  end
endmodule

// File: rtl/blkx_pick.sv
module blkx_pick #(
  parameter int W  = 16,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx
);
  // lowest set bit wins: scan from the top so the lowest assignment lands last
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/blkx_addr_plan.sv
module blkx_addr_plan
  import blkx_pkg::*;
#(
  parameter int AW         = 32,
  parameter int CW         = 5,
  parameter int WORD_BYTES = 4
) (
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] cnt,
  input  xfer_mode_e    mode,
  output logic [AW-1:0] first_addr,
  output logic [AW-1:0] final_base
);
  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  logic [AW-1:0] span;
  assign span = AW'(cnt) * STEP;

  always_comb begin
    unique case (mode)
      XM_INC_AFTER:  first_addr = base;
      XM_INC_BEFORE: first_addr = base + STEP;
      XM_DEC_AFTER:  first_addr = base - span + STEP;
      default:       first_addr = base - span;
    endcase
    final_base = mode[1] ? (base - span) : (base + span);
  end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blkx_pkg::*;
#(
  parameter int AW         = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4,
  localparam int IW        = $clog2(NREG),
  localparam int CW        = $clog2(NREG + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] base_in,
  input  logic [NREG-1:0] reg_mask,
  input  logic [1:0]    mode,
  input  logic          is_load,
  input  logic          wb_en,
  output logic          busy,
  output logic          beat_valid,
  input  logic          beat_ready,
  output logic [AW-1:0] beat_addr,
  output logic [IW-1:0] beat_reg,
  output logic          beat_load,
  output logic          beat_last,
  output logic          done,
  output logic          wb_valid,
  output logic [AW-1:0] wb_value
);
  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  sq_state_e       state_q;
  logic [NREG-1:0] remain_q;
  logic [CW-1:0]   left_q;
  logic [AW-1:0]   addr_q;
  logic [AW-1:0]   fin_q;
  logic [IW-1:0]   idx_q;
  logic            ld_q;
  logic            wb_q;

  logic [CW-1:0]   req_cnt;
  logic [AW-1:0]   plan_first;
  logic [AW-1:0]   plan_final;
  logic [NREG-1:0] remain_clr;
  logic [NREG-1:0] pick_in;
  logic [IW-1:0]   pick_idx;
  logic            accept;
  logic            fire;

  assign accept     = (state_q == SQ_IDLE) && start;
  assign fire       = (state_q == SQ_RUN) && beat_ready;
  assign remain_clr = remain_q & ~(NREG'(1) << idx_q);
  assign pick_in    = (state_q == SQ_IDLE) ? reg_mask : remain_clr;

  blkx_popcnt #(.W(NREG), .CW(CW)) u_cnt (
    .vec (reg_mask),
    .cnt (req_cnt)
  );

  blkx_pick #(.W(NREG), .IW(IW)) u_pick (
    .vec (pick_in),
    .idx (pick_idx)
  );

  blkx_addr_plan #(.AW(AW), .CW(CW), .WORD_BYTES(WORD_BYTES)) u_plan (
    .base       (base_in),
    .cnt        (req_cnt),
    .mode       (xfer_mode_e'(mode)),
    .first_addr (plan_first),
    .final_base (plan_final)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SQ_IDLE;
      remain_q <= '0;
      left_q   <= '0;
      addr_q   <= '0;
      fin_q    <= '0;
      idx_q    <= '0;
      ld_q     <= 1'b0;
      wb_q     <= 1'b0;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          if (accept) begin
            remain_q <= reg_mask;
            left_q   <= req_cnt;
            addr_q   <= plan_first;
            fin_q    <= plan_final;
            idx_q    <= pick_idx;
            ld_q     <= is_load;
            wb_q     <= wb_en;
            state_q  <= (req_cnt == '0) ? SQ_FIN : SQ_RUN;
          end
        end
        SQ_RUN: begin
          if (fire) begin
            if (left_q == CW'(1)) begin
              state_q <= SQ_FIN;
            end else begin
              remain_q <= remain_clr;
              left_q   <= left_q - CW'(1);
              addr_q   <= addr_q + STEP;
              idx_q    <= pick_idx;
            end
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy       = (state_q != SQ_IDLE);
  assign beat_valid = (state_q == SQ_RUN);
  assign beat_addr  = addr_q;
  assign beat_reg   = idx_q;
  assign beat_load  = ld_q;
  assign beat_last  = (state_q == SQ_RUN) && (left_q == CW'(1));
  assign done       = (state_q == SQ_FIN);
  assign wb_valid   = (state_q == SQ_FIN) && wb_q;
  assign wb_value   = fin_q;
endmodule

// File: rtl/blkx_checker.sv
module blkx_checker #(
  parameter int AW = 32,
  parameter int IW = 4,
  parameter int WB = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          beat_valid,
  input logic          beat_ready,
  input logic [AW-1:0] beat_addr,
  input logic [IW-1:0] beat_reg,
  input logic          beat_last,
  input logic          done,
  input logic          wb_valid
);
  a_r1_valid_in_busy: assert property (@(posedge clk) disable iff (rst)
    beat_valid |-> busy);

  a_r7_stall_hold: assert property (@(posedge clk) disable iff (rst)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_addr) && $stable(beat_reg));

  a_r6_addr_step: assert property (@(posedge clk) disable iff (rst)
    beat_valid && beat_ready && !beat_last |=> beat_valid && (beat_addr == $past(beat_addr) + AW'(WB)));

  a_r6_reg_rising: assert property (@(posedge clk) disable iff (rst)
    beat_valid && beat_ready && !beat_last |=> beat_reg > $past(beat_reg));

  a_r9_done_after_last: assert property (@(posedge clk) disable iff (rst)
    beat_valid && beat_ready && beat_last |=> done && !beat_valid);

  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_wb_with_done: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> done);
endmodule

bind blk_xfer_seq blkx_checker #(.AW(AW), .IW(IW), .WB(WORD_BYTES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .beat_valid (beat_valid),
  .beat_ready (beat_ready),
  .beat_addr  (beat_addr),
  .beat_reg   (beat_reg),
  .beat_last  (beat_last),
  .done       (done),
  .wb_valid   (wb_valid)
);

// File: tb/blk_xfer_seq_tb.sv
`timescale 1ns/1ps
module blk_xfer_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] base_in = '0;
  logic [15:0] reg_mask = '0;
  logic [1:0]  mode = '0;
  logic        is_load = 1'b0;
  logic        wb_en = 1'b0;
  logic        beat_ready = 1'b0;
  logic        busy, beat_valid, beat_load, beat_last, done, wb_valid;
  logic [31:0] beat_addr, wb_value;
  logic [3:0]  beat_reg;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  blk_xfer_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .base_in(base_in), .reg_mask(reg_mask),
    .mode(mode), .is_load(is_load), .wb_en(wb_en), .busy(busy),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_addr(beat_addr),
    .beat_reg(beat_reg), .beat_load(beat_load), .beat_last(beat_last),
    .done(done), .wb_valid(wb_valid), .wb_value(wb_value)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_fail++;
      $display("FAIL watchdog R7: act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic string mreq(input logic [1:0] m);
    case (m)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  // {base[32], mask[16], mode[2], load, wb, stall[16], bump}
  localparam int VW = 69;
  localparam int NV = 11;
  localparam logic [VW-1:0] VEC [NV] = '{
    {32'h0000_1000, 16'h0068, 2'b00, 1'b1, 1'b1, 16'h0000, 1'b0},
    {32'h0000_1000, 16'h0068, 2'b01, 1'b0, 1'b1, 16'h0002, 1'b0},
    {32'h0000_2000, 16'h0068, 2'b10, 1'b1, 1'b1, 16'h0000, 1'b1},
    {32'h0000_2000, 16'h0068, 2'b11, 1'b0, 1'b1, 16'h0005, 1'b0},
    {32'h8000_0000, 16'hFFFF, 2'b00, 1'b1, 1'b1, 16'h5555, 1'b1},
    {32'h0000_0040, 16'h8001, 2'b11, 1'b0, 1'b0, 16'h0001, 1'b0},
    {32'h0000_0100, 16'h0000, 2'b00, 1'b1, 1'b1, 16'h0000, 1'b0},
    {32'h0000_0100, 16'h0000, 2'b11, 1'b0, 1'b1, 16'h0000, 1'b1},
    {32'h0000_0010, 16'h0001, 2'b10, 1'b1, 1'b1, 16'h0001, 1'b0},
    {32'h0000_0004, 16'h00F0, 2'b11, 1'b1, 1'b1, 16'h0000, 1'b0},
    {32'hFFFF_FFF8, 16'h0003, 2'b01, 1'b0, 1'b1, 16'h0003, 1'b1}
  };

  task automatic run_op(input logic [31:0] b, input logic [15:0] m, input logic [1:0] md,
                        input logic ld, input logic wb, input logic [15:0] stall,
                        input logic bump);
    int n = $countones(m);
    int nxt = 0;
    logic [31:0] a0, fin;
    case (md)
      2'b00: a0 = b;
      2'b01: a0 = b + 32'd4;
      2'b10: a0 = b - 32'(4 * n) + 32'd4;
      default: a0 = b - 32'(4 * n);
    endcase
    fin = md[1] ? b - 32'(4 * n) : b + 32'(4 * n);
    base_in = b; reg_mask = m; mode = md; is_load = ld; wb_en = wb; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    chk(busy == 1'b1, "R11", "busy after start", 32'(busy), 32'd1);
    for (int k = 0; k < n; k++) begin
      while (!m[nxt]) nxt++;
      chk(beat_valid == 1'b1, "R6", "beat offered", 32'(beat_valid), 32'd1);
      chk(beat_addr == a0 + 32'(4 * k), mreq(md), "beat address", beat_addr, a0 + 32'(4 * k));
      chk(beat_reg == 4'(nxt), "R6", "register index", 32'(beat_reg), 32'(nxt));
      chk(beat_last == (k == n - 1), "R8", "last flag", 32'(beat_last), 32'(k == n - 1));
      chk(beat_load == ld, "R12", "direction", 32'(beat_load), 32'(ld));
      if (bump && k == 0) begin
        start = 1'b1; base_in = ~b; reg_mask = 16'hFFFF; mode = ~md;
      end
      if (stall[k]) begin
        beat_ready = 1'b0;
        @(posedge clk); #1;
        start = 1'b0;
        chk(beat_addr == a0 + 32'(4 * k) && beat_reg == 4'(nxt) && beat_valid,
            "R7", "hold while stalled", beat_addr, a0 + 32'(4 * k));
      end
      beat_ready = 1'b1;
      @(posedge clk); #1;
      beat_ready = 1'b0;
      start = 1'b0;
      nxt++;
    end
    chk(beat_valid == 1'b0, (n == 0) ? "R10" : "R6", "no extra beat", 32'(beat_valid), 32'd0);
    chk(done == 1'b1, (n == 0) ? "R10" : "R9", "done strobe", 32'(done), 32'd1);
    chk(wb_value == fin, (n == 0) ? "R10" : "R9", "updated base", wb_value, fin);
    chk(wb_valid == wb, "R9", "writeback flag", 32'(wb_valid), 32'(wb));
    if (bump) chk(wb_value == fin, "R11", "start while busy ignored", wb_value, fin);
    @(posedge clk); #1;
    chk(done == 1'b0 && busy == 1'b0, "R9", "done single cycle", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    chk(!busy && !beat_valid && !done && !wb_valid, "R1", "reset state",
        {28'd0, busy, beat_valid, done, wb_valid}, 32'd0);
    for (int v = 0; v < NV; v++) begin
      run_op(VEC[v][68:37], VEC[v][36:21], VEC[v][20:19], VEC[v][18], VEC[v][17],
             VEC[v][16:1], VEC[v][0]);
    end
    // reset in the middle of a sequence
    base_in = 32'h300; reg_mask = 16'h00FF; mode = 2'b00; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0; beat_ready = 1'b1;
    @(posedge clk); #1;
    beat_ready = 1'b0; rst = 1'b1;
    @(posedge clk); #1;
    chk(!busy && !beat_valid && !done && !wb_valid, "R1", "reset mid-operation",
        {28'd0, busy, beat_valid, done, wb_valid}, 32'd0);
    rst = 1'b0;
    @(posedge clk); #1;
    chk(!busy && !beat_valid, "R1", "idle after reset", 32'(busy), 32'd0);
    run_op(32'h0000_0200, 16'h0400, 2'b01, 1'b1, 1'b1, 16'h0001, 1'b0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule